// File: doc/BRIEF.md
# Accumulator Upper-Word Increment Unit

This block adds one to a destination operand and returns the updated value together with a set of seven condition flags. The destination is either a 36-bit accumulator, made of a 4-bit extension field, a 16-bit high word and a 16-bit low word, or a plain 16-bit register. For an accumulator, only the 20-bit field formed by the extension and the high word is incremented. The low word is passed through untouched, and the flags describe the full 36-bit result.

An execution stage presents the operand, selects the destination kind and pulses `start_i`. On the next clock edge the result and the flags are captured into registers, and `done_o` is raised for exactly that one cycle. Between operations the registered result and flags keep their last values.

Top module: `incw_unit`

## Requirements
- R1: With `acc_sel_i`=1, `res_o[35:16]` equals `opnd_i[35:16]` plus one, modulo 2^20 (for example 0:0001:0033 gives 0:0002:0033).
- R2: With `acc_sel_i`=1, `res_o[15:0]` equals `opnd_i[15:0]`, even when the low word is 0xFFFF.
- R3: With `acc_sel_i`=0, `res_o[15:0]` equals `opnd_i[15:0]` plus one, modulo 2^16, and `res_o[35:16]` is zero whatever `opnd_i[35:16]` holds.
- R4: In accumulator mode `flag_n_o` equals bit 35 of the result.
- R5: In accumulator mode `flag_z_o` is 1 exactly when result bits 35..16 are all zero.
- R6: In accumulator mode `flag_c_o` is 1 exactly when the upper field wraps from 0xFFFFF to 0x00000.
- R7: In accumulator mode `flag_v_o` is 1 exactly when the input upper field is 0x7FFFF. In both modes `flag_l_o` always equals `flag_v_o`.
- R8: In accumulator mode `flag_e_o` is 1 when result bits 35..31 are not all equal.
- R9: In accumulator mode `flag_u_o` is 1 when result bits 31 and 30 are equal.
- R10: In register mode, N is bit 15 of the result and Z means the 16-bit result is zero. V is set on 0x7FFF to 0x8000 and C on 0xFFFF to 0x0000, while E and U are 0.
- R11: `done_o` is high in the cycle after each cycle in which `start_i` is high and low otherwise. Result and flags change only on such an edge.
- R12: After reset, `res_o`, every flag and `done_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe; operand is captured on this cycle's edge |
| acc_sel_i | input | 1 | 1 = 36-bit accumulator destination, 0 = 16-bit register |
| opnd_i | input | 36 | Operand; register mode uses bits 15..0 only |
| res_o | output | 36 | Registered result |
| flag_l_o | output | 1 | Limit/overflow flag |
| flag_e_o | output | 1 | Extension in use |
| flag_u_o | output | 1 | Unnormalized |
| flag_n_o | output | 1 | Negative |
| flag_z_o | output | 1 | Zero |
| flag_v_o | output | 1 | Signed overflow |
| flag_c_o | output | 1 | Carry out |
| done_o | output | 1 | One-cycle completion strobe |

## Verification
Every state register of the block drives a port directly, so a wrong next value shows up on `res_o` or a flag in the same cycle as `done_o`, one edge after the start strobe. A fault in the carry or overflow path shows only at the boundaries: 0x7FFFF, 0xFFFFF, 0x7FFF and 0xFFFF. A fault in the E and U windows shows only when result bits 35..30 straddle a sign change, so the vectors target those points directly. A faulty hold path shows as a result or flag that changes in a cycle with `done_o` low.

// File: rtl/incw_pkg.sv
package incw_pkg;

    typedef enum logic {
        DEST_REG = 1'b0,
        DEST_ACC = 1'b1
    } dest_e;

    typedef struct packed {
        logic l;
        logic e;
        logic u;
        logic n;
        logic z;
        logic v;
        logic c;
    } flags_t;

endpackage

// File: rtl/incw_inc_field.sv
module incw_inc_field #(
    parameter int W = 20
) (
    input  logic [W-1:0] a_i,
    output logic [W-1:0] sum_o,
    output logic         carry_o,
    output logic         ovf_o
);
    localparam logic [W-1:0] MAX_POS = {1'b0, {(W-1){1'b1}}};

    always_comb begin
        sum_o   = a_i + {{(W-1){1'b0}}, 1'b1};
        carry_o = &a_i;
        ovf_o   = (a_i == MAX_POS);
    end
endmodule

// File: rtl/incw_flag_gen.sv
module incw_flag_gen
    import incw_pkg::*;
#(
    parameter int EXT_W = 4,
    parameter int MSP_W = 16,
    parameter int LSP_W = 16,
    parameter int REG_W = 16,
    localparam int ACC_W = EXT_W + MSP_W + LSP_W,
    localparam int UP_W  = EXT_W + MSP_W
) (
    input  dest_e             dest_i,
    input  logic [ACC_W-1:0]  acc_res_i,
    input  logic              acc_carry_i,
    input  logic              acc_ovf_i,
    input  logic [REG_W-1:0]  reg_res_i,
    input  logic              reg_carry_i,
    input  logic              reg_ovf_i,
    output flags_t            flags_o
);
    localparam int SIGN_POS = ACC_W - EXT_W - 1;

    logic [EXT_W:0] ext_win;
    logic           ext_same;

    always_comb begin
        ext_win  = acc_res_i[ACC_W-1:SIGN_POS];
        ext_same = (&ext_win) | ~(|ext_win);
        flags_o  = '0;
        if (dest_i == DEST_ACC) begin
            flags_o.n = acc_res_i[ACC_W-1];
            flags_o.z = ~(|acc_res_i[ACC_W-1:ACC_W-UP_W]);
            flags_o.c = acc_carry_i;
            flags_o.v = acc_ovf_i;
            flags_o.e = ~ext_same;
            flags_o.u = (acc_res_i[SIGN_POS] == acc_res_i[SIGN_POS-1]);
        end else begin
            flags_o.n = reg_res_i[REG_W-1];
            flags_o.z = ~(|reg_res_i);
            flags_o.c = reg_carry_i;
            flags_o.v = reg_ovf_i;
        end
        flags_o.l = flags_o.v;
    end
endmodule

// File: rtl/incw_unit.sv
module incw_unit
    import incw_pkg::*;
#(
    parameter int EXT_W = 4,
    parameter int MSP_W = 16,
    parameter int LSP_W = 16,
    parameter int REG_W = 16,
    localparam int ACC_W = EXT_W + MSP_W + LSP_W,
    localparam int UP_W  = EXT_W + MSP_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             acc_sel_i,
    input  logic [ACC_W-1:0] opnd_i,
    output logic [ACC_W-1:0] res_o,
    output logic             flag_l_o,
    output logic             flag_e_o,
    output logic             flag_u_o,
    output logic             flag_n_o,
    output logic             flag_z_o,
    output logic             flag_v_o,
    output logic             flag_c_o,
    output logic             done_o
);
    typedef struct packed {
        logic [ACC_W-1:0] res;
        flags_t           flags;
        logic             done;
    } state_t;

    state_t st_d, st_q;

    dest_e            dest;
    logic [UP_W-1:0]  up_sum;
    logic             up_carry, up_ovf;
    logic [REG_W-1:0] reg_sum;
    logic             reg_carry, reg_ovf;
    logic [ACC_W-1:0] acc_res;
    flags_t           flags_nx;

    assign dest = acc_sel_i ? DEST_ACC : DEST_REG;

    incw_inc_field #(.W(UP_W)) u_up_inc (
        .a_i     (opnd_i[ACC_W-1:LSP_W]),
        .sum_o   (up_sum),
        .carry_o (up_carry),
        .ovf_o   (up_ovf)
    );

    incw_inc_field #(.W(REG_W)) u_reg_inc (
        .a_i     (opnd_i[REG_W-1:0]),
        .sum_o   (reg_sum),
        .carry_o (reg_carry),
        .ovf_o   (reg_ovf)
    );

    assign acc_res = {up_sum, opnd_i[LSP_W-1:0]};

    incw_flag_gen #(
        .EXT_W (EXT_W),
        .MSP_W (MSP_W),
        .LSP_W (LSP_W),
        .REG_W (REG_W)
    ) u_flags (
        .dest_i      (dest),
        .acc_res_i   (acc_res),
        .acc_carry_i (up_carry),
        .acc_ovf_i   (up_ovf),
        .reg_res_i   (reg_sum),
        .reg_carry_i (reg_carry),
        .reg_ovf_i   (reg_ovf),
        .flags_o     (flags_nx)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = start_i;
        if (start_i) begin
            st_d.flags = flags_nx;
            if (dest == DEST_ACC) begin
                st_d.res = acc_res;
            end else begin
                st_d.res = {{(ACC_W-REG_W){1'b0}}, reg_sum};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign res_o    = st_q.res;
    assign flag_l_o = st_q.flags.l;
    assign flag_e_o = st_q.flags.e;
    assign flag_u_o = st_q.flags.u;
    assign flag_n_o = st_q.flags.n;
    assign flag_z_o = st_q.flags.z;
    assign flag_v_o = st_q.flags.v;
    assign flag_c_o = st_q.flags.c;
    assign done_o   = st_q.done;
endmodule

// File: rtl/incw_unit_chk.sv
module incw_unit_chk #(
    parameter int EXT_W = 4,
    parameter int MSP_W = 16,
    parameter int LSP_W = 16,
    localparam int ACC_W = EXT_W + MSP_W + LSP_W,
    localparam int UP_W  = EXT_W + MSP_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             acc_sel_i,
    input logic [ACC_W-1:0] opnd_i,
    input logic [ACC_W-1:0] res_o,
    input logic             flag_l_o,
    input logic             flag_n_o,
    input logic             flag_z_o,
    input logic             done_o
);
    // R11
    done_follows_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> done_o);

    // R11
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> !done_o);

    // R11
    res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> $stable(res_o));

    // R1
    upper_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && acc_sel_i) |=>
        res_o[ACC_W-1:LSP_W] == UP_W'($past(opnd_i[ACC_W-1:LSP_W]) + 1'b1));

    // R2
    low_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && acc_sel_i) |=> res_o[LSP_W-1:0] == $past(opnd_i[LSP_W-1:0]));

    // R4
    neg_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && acc_sel_i) |=> flag_n_o == res_o[ACC_W-1]);

    // R5
    zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && acc_sel_i) |=> flag_z_o == (res_o[ACC_W-1:LSP_W] == '0));

    // R7
    limit_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> flag_l_o == $past(opnd_i[ACC_W-1:LSP_W] == {1'b0, {(UP_W-1){1'b1}}}
                                     && acc_sel_i)
                   || !$past(acc_sel_i));
endmodule

bind incw_unit incw_unit_chk #(
    .EXT_W (EXT_W),
    .MSP_W (MSP_W),
    .LSP_W (LSP_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .acc_sel_i (acc_sel_i),
    .opnd_i    (opnd_i),
    .res_o     (res_o),
    .flag_l_o  (flag_l_o),
    .flag_n_o  (flag_n_o),
    .flag_z_o  (flag_z_o),
    .done_o    (done_o)
);

// File: tb/tb_incw_unit.sv
module tb_incw_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        acc_sel_i = 1'b0;
    logic [35:0] opnd_i = '0;
    logic [35:0] res_o;
    logic        flag_l_o, flag_e_o, flag_u_o, flag_n_o, flag_z_o, flag_v_o, flag_c_o;
    logic        done_o;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    incw_unit dut (
        .clk (clk), .rst_n (rst_n), .start_i (start_i), .acc_sel_i (acc_sel_i),
        .opnd_i (opnd_i), .res_o (res_o),
        .flag_l_o (flag_l_o), .flag_e_o (flag_e_o), .flag_u_o (flag_u_o),
        .flag_n_o (flag_n_o), .flag_z_o (flag_z_o), .flag_v_o (flag_v_o),
        .flag_c_o (flag_c_o), .done_o (done_o)
    );

    // flag order: {L, E, U, N, Z, V, C}
    typedef struct packed {
        logic        acc;
        logic [35:0] op;
        logic [35:0] res;
        logic [6:0]  fl;
    } vec_t;

    localparam vec_t VECS [10] = '{
        '{1'b1, 36'h0_0001_0033, 36'h0_0002_0033, 7'b0010000},
        '{1'b1, 36'hF_FFFF_1234, 36'h0_0000_1234, 7'b0010101},
        '{1'b1, 36'h7_FFFF_00AA, 36'h8_0000_00AA, 7'b1111010},
        '{1'b1, 36'h0_3FFF_5555, 36'h0_4000_5555, 7'b0000000},
        '{1'b1, 36'h0_7FFF_0000, 36'h0_8000_0000, 7'b0100000},
        '{1'b1, 36'hF_BFFF_FFFF, 36'hF_C000_FFFF, 7'b0011000},
        '{1'b0, 36'hA_BCDE_7FFF, 36'h0_0000_8000, 7'b1001010},
        '{1'b0, 36'h3_0000_FFFF, 36'h0_0000_0000, 7'b0000101},
        '{1'b0, 36'h0_0000_0041, 36'h0_0000_0042, 7'b0000000},
        '{1'b1, 36'h0_0000_FFFF, 36'h0_0001_FFFF, 7'b0010000}
    };

    task automatic check(input string tag, input logic [35:0] act, input logic [35:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [6:0] flags_now();
        return {flag_l_o, flag_e_o, flag_u_o, flag_n_o, flag_z_o, flag_v_o, flag_c_o};
    endfunction

    task automatic run_op(input logic acc, input logic [35:0] op);
        @(negedge clk);
        acc_sel_i = acc;
        opnd_i    = op;
        start_i   = 1'b1;
        @(negedge clk);
        start_i   = 1'b0;
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        logic [35:0] held;
        logic [6:0]  held_fl;
        repeat (3) @(negedge clk);
        // R12: reset state
        check("R12 res", res_o, '0);
        check("R12 flags", {29'd0, flags_now()}, '0);
        check("R12 done", {35'd0, done_o}, '0);
        rst_n = 1'b1;

        foreach (VECS[i]) begin
            run_op(VECS[i].acc, VECS[i].op);
            check("R11 done", {35'd0, done_o}, 36'd1);
            if (VECS[i].acc) begin
                check("R1 upper", {16'd0, res_o[35:16]}, {16'd0, VECS[i].res[35:16]});
                check("R2 low",   {20'd0, res_o[15:0]},  {20'd0, VECS[i].res[15:0]});
                check("R7 L", {35'd0, flag_l_o}, {35'd0, VECS[i].fl[6]});
                check("R8 E", {35'd0, flag_e_o}, {35'd0, VECS[i].fl[5]});
                check("R9 U", {35'd0, flag_u_o}, {35'd0, VECS[i].fl[4]});
                check("R4 N", {35'd0, flag_n_o}, {35'd0, VECS[i].fl[3]});
                check("R5 Z", {35'd0, flag_z_o}, {35'd0, VECS[i].fl[2]});
                check("R7 V", {35'd0, flag_v_o}, {35'd0, VECS[i].fl[1]});
                check("R6 C", {35'd0, flag_c_o}, {35'd0, VECS[i].fl[0]});
            end else begin
                check("R3 reg result", res_o, VECS[i].res);
                check("R10 reg flags", {29'd0, flags_now()}, {29'd0, VECS[i].fl});
            end
        end

        // R11: no start -> done drops, result and flags hold
        held    = res_o;
        held_fl = flags_now();
        @(negedge clk);
        check("R11 done low", {35'd0, done_o}, '0);
        opnd_i    = 36'h7_FFFF_0000;
        acc_sel_i = 1'b1;
        repeat (2) @(negedge clk);
        check("R11 res hold", res_o, held);
        check("R11 flag hold", {29'd0, flags_now()}, {29'd0, held_fl});

        // R11: back-to-back starts give back-to-back results
        @(negedge clk);
        acc_sel_i = 1'b0; opnd_i = 36'h0_0000_0010; start_i = 1'b1;
        @(negedge clk);
        check("R11 b2b first", res_o, 36'h0_0000_0011);
        acc_sel_i = 1'b1; opnd_i = 36'h0_0010_0000;
        @(negedge clk);
        start_i = 1'b0;
        check("R11 b2b second", res_o, 36'h0_0011_0000);
        check("R11 b2b done", {35'd0, done_o}, 36'd1);

        // R12: reset mid-operation clears everything
        rst_n = 1'b0;
        @(negedge clk);
        check("R12 reapplied", {res_o, 7'd0} >> 7 | {29'd0, flags_now()} | {35'd0, done_o}, '0);
        rst_n = 1'b1;

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule